// File: doc/BRIEF.md
# Eight-bit divide step unit

This block advances a software-driven 32-bit division by eight quotient bits per call. The caller holds a 64-bit working pair: the partial remainder sits in the upper word and the dividend, which becomes the quotient as bits shift in, sits in the lower word. The caller presents this pair with a divisor and a mode and pulses start. The unit then runs one radix-2 iteration per clock for eight clocks and returns the updated pair. Four calls in a row retire a full 32-bit quotient.

Signed division leaves the quotient one's-complement biased and can leave a remainder equal to plus or minus the divisor. A separate single-cycle adjust mode corrects both. Unsigned division needs no correction. Preparing the pair before the first call (sign-extending the dividend into the upper word, or zeroing it) stays outside the block.

Top module: `div_step_unit`

## Requirements
- R1: After reset, pair_o is zero and busy_o and done_o are low.
- R2: The unit accepts start_i while idle. With mode_i 2'b00 (signed step) or 2'b01 (unsigned step), busy_o is high from the next cycle for exactly 8 cycles. done_o pulses for one cycle in the cycle where busy_o falls.
- R3: The unit ignores start_i while busy_o is high. The running divide keeps its operands, and its result does not change.
- R4: Signed step. The quotient sign is pair bit 63 XOR divisor bit 31. Each iteration adds the divisor when the quotient sign is 1 and subtracts it when the sign is 0. The trial sum is kept as the new remainder only when its bit 31 equals the dividend sign (pair bit 63 at start). The new quotient bit is the inverted quotient sign when the sum is kept, and the quotient sign when it is not.
- R5: Unsigned step. The trial value is the 32-bit shifted remainder minus the divisor. It is kept when it is not negative, and the quotient bit is 1 when kept and 0 otherwise.
- R6: Each iteration shifts the 64-bit pair left by one, moving lower bit 31 into the remainder. The result is {remainder, quotient} in bits 63:32 and 31:0, with exactly 8 new quotient bits per call.
- R7: Adjust mode (mode_i bit 1 set, so 2'b10 or 2'b11) finishes in one cycle. busy_o stays low and done_o is high in the next cycle. The quotient is incremented when (quotient sign AND NOT equal-negative) OR equal-positive. Equal-positive means pair bit 63 is set and the upper word equals the divisor. Equal-negative means pair bit 63 is set and the upper word equals the negated divisor.
- R8: In adjust mode, the remainder becomes zero when either equality holds and is passed through unchanged otherwise.
- R9: A signed divide runs four signed steps and then one adjust, starting from a pair whose upper word is the sign extension of the dividend. It yields the truncated quotient and a remainder with the dividend's sign. This holds for any non-zero divisor, except a dividend of -2^31 with a divisor of -1.
- R10: An unsigned divide runs four unsigned steps, starting from a zero upper word. It yields the exact quotient and remainder for divisors from 1 to 2^31-1.
- R11: pair_o holds its value while the unit is idle, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (used only when idle) |
| mode_i | input | 2 | 00 signed step, 01 unsigned step, 1x adjust |
| pair_i | input | 64 | Working pair {remainder, dividend/quotient} |
| divisor_i | input | 32 | Divisor |
| pair_o | output | 64 | Updated pair {remainder, quotient} |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the handshake rules: busy and done never both high, done lasting one cycle, done following busy falling, and the iteration count staying below eight;
- that the divisor is frozen while busy;
- that the result is held while idle;
- that an adjust start never raises busy.

The arithmetic can only be shown by the bench's scenarios. The bench checks directed single steps in each mode and both adjust equality cases. It then chains a full divide for sign-corner and mixed operands against a reference quotient and remainder. A start pulse in the middle of a run is also shown to leave the result unchanged.

// File: rtl/div_step_pkg.sv
package div_step_pkg;
  typedef enum logic [1:0] {
    MODE_SSTEP   = 2'b00,
    MODE_USTEP   = 2'b01,
    MODE_ADJ     = 2'b10,
    MODE_ADJ_ALT = 2'b11
  } dstep_mode_e;

  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned STEPS_DEF  = 8;
endpackage

// File: rtl/div_step_iter.sv
// One radix-2 iteration, signed or unsigned.
module div_step_iter #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  input  logic         uns_i,
  input  logic         dvd_sign_i,
  input  logic         q_sign_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_sh;
  logic [W-1:0] addend;
  logic [W-1:0] trial_s;
  logic [W:0]   trial_u;
  logic         keep_s;
  logic         keep_u;
  logic         q_bit;

  always_comb begin
    rem_sh  = {rem_i[W-2:0], quo_i[W-1]};
    addend  = q_sign_i ? div_i : (~div_i + W'(1));
    trial_s = rem_sh + addend;
    trial_u = {1'b0, rem_sh} - {1'b0, div_i};
    keep_s  = (trial_s[W-1] == dvd_sign_i);
    keep_u  = ~trial_u[W];
    if (uns_i) begin
      rem_o = keep_u ? trial_u[W-1:0] : rem_sh;
      q_bit = keep_u;
    end else begin
      rem_o = keep_s ? trial_s : rem_sh;
      q_bit = keep_s ? ~q_sign_i : q_sign_i;
    end
    quo_o = {quo_i[W-2:0], q_bit};
  end
endmodule

// File: rtl/div_step_adjust.sv
// Post-division correction of quotient and remainder.
module div_step_adjust #(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] pair_i,
  input  logic [W-1:0]   div_i,
  output logic [2*W-1:0] pair_o
);
  logic [W-1:0] hi, lo, neg_div;
  logic x_sign, q_sign, eq_pos, eq_neg, inc;

  always_comb begin
    hi      = pair_i[2*W-1:W];
    lo      = pair_i[W-1:0];
    neg_div = '0 - div_i;
    x_sign  = pair_i[2*W-1];
    q_sign  = x_sign ^ div_i[W-1];
    eq_pos  = x_sign & (hi == div_i);
    eq_neg  = x_sign & (hi == neg_div);
    inc     = (q_sign & ~eq_neg) | eq_pos;
    pair_o[W-1:0]   = inc ? lo + W'(1) : lo;
    pair_o[2*W-1:W] = (eq_pos | eq_neg) ? '0 : hi;
  end
endmodule

// File: rtl/div_step_ctrl.sv
// Start/busy/done sequencing and iteration count.
module div_step_ctrl #(
  parameter int unsigned ITER = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic adj_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(ITER + 1);
  localparam int unsigned LAST  = ITER - 1;

  logic [CNT_W-1:0] cnt_q;
  logic busy_q, done_q, last;

  assign accept_o = start_i & ~busy_q;
  assign last     = (cnt_q == CNT_W'(LAST));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= '0;
      busy_q <= ~adj_i;
      done_q <= adj_i;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      busy_q <= ~last;
      done_q <= last;
    end else begin
      done_q <= 1'b0;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= CNT_W'(LAST)));
  // R2
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(accept_o));
  // R2
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R7
  adj_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && adj_i) |=> (done_o && !busy_o));
  // R2
  step_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !adj_i) |=> busy_o);
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned STEPS  = STEPS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [2*DATA_W-1:0] pair_i,
  input  logic [DATA_W-1:0]   divisor_i,
  output logic [2*DATA_W-1:0] pair_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned PW = 2 * DATA_W;

  dstep_mode_e mode;
  logic is_adj, accept;
  logic [DATA_W-1:0] rem_q, quo_q, div_q, rem_nx, quo_nx;
  logic dvd_sign_q, q_sign_q, uns_q;
  logic [PW-1:0] adj_pair;

  assign mode   = dstep_mode_e'(mode_i);
  assign is_adj = (mode == MODE_ADJ) || (mode == MODE_ADJ_ALT);

  div_step_ctrl #(.ITER(STEPS)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .adj_i    (is_adj),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  div_step_iter #(.W(DATA_W)) i_iter (
    .rem_i      (rem_q),
    .quo_i      (quo_q),
    .div_i      (div_q),
    .uns_i      (uns_q),
    .dvd_sign_i (dvd_sign_q),
    .q_sign_i   (q_sign_q),
    .rem_o      (rem_nx),
    .quo_o      (quo_nx)
  );

  div_step_adjust #(.W(DATA_W)) i_adj (
    .pair_i (pair_i),
    .div_i  (divisor_i),
    .pair_o (adj_pair)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q      <= '0;
      quo_q      <= '0;
      div_q      <= '0;
      dvd_sign_q <= 1'b0;
      q_sign_q   <= 1'b0;
      uns_q      <= 1'b0;
    end else if (accept) begin
      div_q      <= divisor_i;
      uns_q      <= (mode == MODE_USTEP);
      dvd_sign_q <= pair_i[PW-1];
      q_sign_q   <= pair_i[PW-1] ^ divisor_i[DATA_W-1];
      if (is_adj) {rem_q, quo_q} <= adj_pair;
      else        {rem_q, quo_q} <= pair_i;
    end else if (busy_o) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
    end
  end

  assign pair_o = {rem_q, quo_q};

  // R3
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(div_q));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(pair_o));
endmodule

// File: tb/test_div_step_unit.sv
module test_div_step_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] pair = '0;
  logic [31:0] dvs = '0;
  logic [63:0] pair_o;
  logic        busy, done;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  div_step_unit i_div_step_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .pair_i(pair), .divisor_i(dvs), .pair_o(pair_o), .busy_o(busy), .done_o(done)
  );

  // {signed flag, dividend, divisor}
  localparam int NV = 16;
  localparam logic [64:0] VEC [0:NV-1] = '{
    {1'b1, 32'hFFFFFFF9, 32'h00000002},
    {1'b1, 32'h00000007, 32'hFFFFFFFE},
    {1'b1, 32'hFFFFFFF9, 32'hFFFFFFFE},
    {1'b1, 32'hFFFFFFF8, 32'hFFFFFFFE},
    {1'b1, 32'h00000064, 32'h00000007},
    {1'b1, 32'hFFFFFF9C, 32'h00000007},
    {1'b1, 32'h80000000, 32'h00000001},
    {1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF},
    {1'b1, 32'h7FFFFFFF, 32'h00000003},
    {1'b1, 32'hFFFFFFFF, 32'h00000005},
    {1'b1, 32'h00000000, 32'h00000009},
    {1'b1, 32'h00BC614E, 32'hFFFFFC18},
    {1'b0, 32'hFFFFFFFF, 32'h7FFFFFFF},
    {1'b0, 32'h000F4240, 32'h00000003},
    {1'b0, 32'h00000005, 32'h00000009},
    {1'b0, 32'hDEADBEEF, 32'h00012345}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [63:0] p, input logic [31:0] d,
                        output logic [63:0] res);
    int n;
    @(negedge clk);
    start = 1'b1; mode = m; pair = p; dvs = d;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    if (m[1]) begin
      chk(done && !busy, "R7 adjust one cycle", {62'd0, busy, done}, 64'd1);
    end else begin
      chk(busy, "R2 busy after start", {63'd0, busy}, 64'd1);
      while (!done && n < 30) begin
        @(negedge clk);
        n++;
      end
      chk(n == 8, "R2 eight-cycle latency", 64'(n), 64'd8);
    end
    res = pair_o;
    @(negedge clk);
    chk(!done, "R2 done single pulse", {63'd0, done}, 64'd0);
    chk(pair_o == res, "R11 result held", pair_o, res);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pair_o == 64'd0 && !busy && !done, "R1 reset state", pair_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6: 0xFF / 3 = 0x55 r 0, one unsigned call
    run_op(2'b01, {32'd0, 32'hFF000000}, 32'd3, r);
    chk(r == {32'd0, 32'h00000055}, "R5 R6 unsigned single step", r, {32'd0, 32'h55});
    // R4: 0x64 / 7 = 14 r 2, one signed call, positive operands
    run_op(2'b00, {32'd0, 32'h64000000}, 32'd7, r);
    chk(r == {32'd2, 32'h0000000E}, "R4 signed single step", r, {32'd2, 32'hE});
    // R4: negative dividend, one call shifting in ones
    run_op(2'b00, {32'hFFFFFFFF, 32'hF9000000}, 32'd2, r);
    chk(r == {32'hFFFFFFFF, 32'h000000FC}, "R4 signed negative step", r, {32'hFFFFFFFF, 32'hFC});
    // R7 R8 equal-positive
    run_op(2'b10, {32'hFFFFFFFE, 32'hFFFFFFFC}, 32'hFFFFFFFE, r);
    chk(r == {32'd0, 32'hFFFFFFFD}, "R7 R8 equal-positive", r, {32'd0, 32'hFFFFFFFD});
    // R7 R8 equal-negative
    run_op(2'b10, {32'hFFFFFFFE, 32'd7}, 32'd2, r);
    chk(r == {32'd0, 32'd7}, "R7 R8 equal-negative", r, {32'd0, 32'd7});
    // R7 mode 11, positive quotient sign: pass through
    run_op(2'b11, {32'd5, 32'd10}, 32'd3, r);
    chk(r == {32'd5, 32'd10}, "R7 alt adjust no change", r, {32'd5, 32'd10});
    // R7 quotient sign set, no equality: increment only
    run_op(2'b10, {32'd1, 32'hFFFFFFFC}, 32'hFFFFFFFE, r);
    chk(r == {32'd1, 32'hFFFFFFFD}, "R7 increment", r, {32'd1, 32'hFFFFFFFD});

    // R3: start during busy ignored
    @(negedge clk);
    start = 1'b1; mode = 2'b01; pair = {32'd0, 32'hFF000000}; dvs = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; mode = 2'b00; pair = 64'h1234_5678_9ABC_DEF0; dvs = 32'd7;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R3 still busy", {63'd0, busy}, 64'd1);
    while (!done) @(negedge clk);
    chk(pair_o == {32'd0, 32'h55}, "R3 start while busy ignored", pair_o, {32'd0, 32'h55});
    // R11 idle hold
    repeat (4) @(negedge clk);
    chk(pair_o == {32'd0, 32'h55} && !done, "R11 idle hold", pair_o, {32'd0, 32'h55});

    // R9 R10 chained divides
    for (int i = 0; i < NV; i++) begin
      logic        sg;
      logic [31:0] a, b, eq, er;
      logic [63:0] w;
      sg = VEC[i][64]; a = VEC[i][63:32]; b = VEC[i][31:0];
      if (sg) begin
        eq = $signed(a) / $signed(b);
        er = $signed(a) % $signed(b);
        w = {{32{a[31]}}, a};
        for (int k = 0; k < 4; k++) run_op(2'b00, w, b, w);
        run_op(2'b10, w, b, w);
        chk(w == {er, eq}, "R9 signed divide", w, {er, eq});
      end else begin
        eq = a / b;
        er = a % b;
        w = {32'd0, a};
        for (int k = 0; k < 4; k++) run_op(2'b01, w, b, w);
        chk(w == {er, eq}, "R10 unsigned divide", w, {er, eq});
      end
    end
    finish_run();
  end
endmodule